// File: doc/BRIEF.md
# Cache Access Miss Classifier

This block observes a stream of byte addresses presented to a small tag-only cache model. It labels each access with one of four outcomes: a hit, a cold miss, a conflict miss or a capacity miss. The modelled cache holds eight lines of 16 bytes. A parameter selects the organisation: direct mapped, 2-way, 4-way or fully associative. Only tags, valid bits and replacement order are kept. There is no data storage, no write handling and no memory traffic.

Each miss is sorted using two structures that run beside the real cache. The first is a record of every line address touched since reset, which identifies cold misses. The second is a shadow fully associative cache of the same capacity. When the shadow cache would have hit on a repeated line, the miss is a conflict miss; when it would also have missed, the miss is a capacity miss. The result appears one cycle after the access strobe. It can feed a performance counter or a trace sink.

Top module: `cache_miss_classifier`

## Requirements
- R1: Address bits 3:0 are the byte offset within a line and play no part in the outcome. The set index is address bits 6:4 when direct mapped, bits 5:4 for 2-way, bit 4 for 4-way, and absent for fully associative. The tag is all address bits above the index.
- R2: Every access gets exactly one class code: 2'b00 hit, 2'b01 cold miss, 2'b10 conflict miss, 2'b11 capacity miss. A hit in the real cache takes priority over every miss class.
- R3: `res_valid` is high in exactly the cycle after a cycle with `acc_valid` high. `res_class` holds that access's class in the same cycle. `res_valid` is low otherwise.
- R4: A miss whose line address (bits 31:4) has not been accessed since reset is a cold miss.
- R5: A miss on a line seen before is a conflict miss when the shadow fully associative eight-line cache holds that line.
- R6: A miss on a line seen before is a capacity miss when the shadow cache also misses.
- R7: Each set of the real cache uses true LRU replacement. Every miss fills the line into an empty way if one exists, and otherwise into the least recently used way.
- R8: The shadow cache uses true LRU over all eight lines and fills on every miss.
- R9: The first-touch record holds `SEEN_DEPTH` line addresses. A new line that arrives when the record is full is not stored and sets `seen_full_err`. The flag stays set until reset.
- R10: A synchronous active-low reset clears every valid bit, the LRU order, the first-touch record, `seen_full_err` and `res_valid`.
- R11: Accesses on consecutive cycles are each classified against the state left by the one before. A repeat of the same line on the next cycle is a hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Access strobe |
| acc_addr | input | 32 | Byte address of the access |
| res_valid | output | 1 | Result strobe, one cycle after `acc_valid` |
| res_class | output | 2 | Class code: 00 hit, 01 cold, 10 conflict, 11 capacity |
| seen_full_err | output | 1 | Sticky flag: the first-touch record overflowed |

## Verification
Every result is due exactly one clock edge after its strobe. The bench raises `acc_valid` on a falling edge and drops it on the next falling edge. It reads `res_valid`, `res_class` and `seen_full_err` at that second falling edge, after the single registering edge has passed. To test the R3 timing, the bench reads `res_valid` again one falling edge later, where it must be low. For back-to-back accesses, each result is read at the falling edge that follows its own rising edge.

// File: rtl/cmc_pkg.sv
// Shared class codes for the cache access miss classifier.
package cmc_pkg;
    typedef enum logic [1:0] {
        CLS_HIT      = 2'b00,
        CLS_COLD     = 2'b01,
        CLS_CONFLICT = 2'b10,
        CLS_CAPACITY = 2'b11
    } cls_e;
endpackage

// File: rtl/cmc_lru_set.sv
// One associative set of tags with true LRU ordering kept as per-way ages.
// Assumes: the ages of valid ways are distinct, with 0 as most recently used.
// On upd, a hit promotes its way; a miss fills the lowest empty way or, if
// no way is empty, the way whose age is WAYS-1.
module cmc_lru_set #(
    parameter int WAYS  = 2,
    parameter int TAG_W = 26
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd,
    input  logic [TAG_W-1:0] tag_in,
    output logic             hit
);
    localparam int AGE_W = $clog2(WAYS) + 1;
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

    logic [TAG_W-1:0] tag_q [WAYS];
    logic [AGE_W-1:0] age_q [WAYS];
    logic [WAYS-1:0]  vld_q;
    logic [WAYS-1:0]  hit_vec;
    logic [WAY_W-1:0] hit_slot, inv_slot, old_slot, slot;
    logic             inv_found;
    logic [AGE_W-1:0] ref_age;

    // Compare every way's tag against the lookup tag.
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_vec[w] = vld_q[w] && (tag_q[w] == tag_in);
    end
    assign hit = |hit_vec;

    // Pick the way to touch: the hit way, else the lowest empty way, else the oldest way.
    always_comb begin
        hit_slot  = '0;
        inv_slot  = '0;
        old_slot  = '0;
        inv_found = 1'b0;
        for (int w = 0; w < WAYS; w++) begin
            if (hit_vec[w]) hit_slot = WAY_W'(w);
            if (vld_q[w] && age_q[w] == AGE_W'(WAYS - 1)) old_slot = WAY_W'(w);
        end
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!vld_q[w]) begin
                inv_slot  = WAY_W'(w);
                inv_found = 1'b1;
            end
        end
        slot    = hit ? hit_slot : (inv_found ? inv_slot : old_slot);
        ref_age = vld_q[slot] ? age_q[slot] : AGE_W'(WAYS);
    end

    // Update tags, valid bits and ages for an access to this set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            for (int w = 0; w < WAYS; w++) begin
                tag_q[w] <= '0;
                age_q[w] <= '0;
            end
        end else if (upd) begin
            for (int w = 0; w < WAYS; w++) begin
                if (slot == WAY_W'(w)) begin
                    vld_q[w] <= 1'b1;
                    tag_q[w] <= tag_in;
                    age_q[w] <= '0;
                end else if (vld_q[w] && age_q[w] < ref_age) begin
                    age_q[w] <= age_q[w] + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/cmc_real_cache.sv
// The modelled cache: LINES lines in LINES/WAYS sets of WAYS ways each.
// Assumes: LINES and WAYS are powers of two and WAYS <= LINES.
// The index is the low bits of the line address and the tag is the rest.
module cmc_real_cache #(
    parameter int LINES  = 8,
    parameter int WAYS   = 1,
    parameter int LINE_W = 28
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd,
    input  logic [LINE_W-1:0] line_in,
    output logic              hit
);
    localparam int SETS  = LINES / WAYS;
    localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 0;
    localparam int SEL_W = (SETS > 1) ? IDX_W : 1;
    localparam int TAG_W = LINE_W - IDX_W;

    logic [SEL_W-1:0] set_idx;
    logic [TAG_W-1:0] tag;
    logic [SETS-1:0]  set_hit;

    // Split the line address into an index and a tag.
    if (SETS > 1) begin : g_idx
        assign set_idx = line_in[IDX_W-1:0];
    end else begin : g_noidx
        assign set_idx = '0;
    end
    assign tag = line_in[LINE_W-1 -: TAG_W];

    // One LRU set per index value.
    for (genvar s = 0; s < SETS; s++) begin : g_set
        cmc_lru_set #(.WAYS(WAYS), .TAG_W(TAG_W)) u_set (
            .clk    (clk),
            .rst_n  (rst_n),
            .upd    (upd && (set_idx == SEL_W'(s))),
            .tag_in (tag),
            .hit    (set_hit[s])
        );
    end
    assign hit = set_hit[set_idx];
endmodule

// File: rtl/cmc_seen_cam.sv
// Record of line addresses touched since reset, searched associatively.
// Assumes: at most one insertion per cycle. A new line that arrives when the
// record is full is dropped and raises a sticky overflow flag.
module cmc_seen_cam #(
    parameter int DEPTH  = 64,
    parameter int LINE_W = 28
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd,
    input  logic [LINE_W-1:0] line_in,
    output logic              seen,
    output logic              ovf
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [LINE_W-1:0] ent_q [DEPTH];
    logic [CNT_W-1:0]  cnt_q;
    logic [DEPTH-1:0]  match;

    // Search the filled entries for the line.
    for (genvar i = 0; i < DEPTH; i++) begin : g_match
        assign match[i] = (CNT_W'(i) < cnt_q) && (ent_q[i] == line_in);
    end
    assign seen = |match;

    // Append a new line, or flag that it did not fit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            ovf   <= 1'b0;
            for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
        end else if (upd && !seen) begin
            if (cnt_q == CNT_W'(DEPTH)) begin
                ovf <= 1'b1;
            end else begin
                for (int i = 0; i < DEPTH; i++)
                    if (CNT_W'(i) == cnt_q) ent_q[i] <= line_in;
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/cache_miss_classifier.sv
// Classifies each access as hit, cold, conflict or capacity miss.
// Assumes: one access per cycle at most. The real cache, the shadow
// fully associative cache and the first-touch record all update on every
// access, and the class is registered one cycle later.
module cache_miss_classifier #(
    parameter int ADDR_W     = 32,
    parameter int OFF_W      = 4,
    parameter int LINES      = 8,
    parameter int WAYS       = 1,
    parameter int SEEN_DEPTH = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic              res_valid,
    output logic [1:0]        res_class,
    output logic              seen_full_err
);
    import cmc_pkg::*;
    localparam int LINE_W = ADDR_W - OFF_W;

    logic [LINE_W-1:0] line;
    logic              real_hit, shadow_hit, was_seen;
    cls_e              cls;

    assign line = acc_addr[ADDR_W-1:OFF_W];

    cmc_real_cache #(.LINES(LINES), .WAYS(WAYS), .LINE_W(LINE_W)) u_real (
        .clk(clk), .rst_n(rst_n), .upd(acc_valid), .line_in(line), .hit(real_hit)
    );

    cmc_lru_set #(.WAYS(LINES), .TAG_W(LINE_W)) u_shadow (
        .clk(clk), .rst_n(rst_n), .upd(acc_valid), .tag_in(line), .hit(shadow_hit)
    );

    cmc_seen_cam #(.DEPTH(SEEN_DEPTH), .LINE_W(LINE_W)) u_seen (
        .clk(clk), .rst_n(rst_n), .upd(acc_valid), .line_in(line),
        .seen(was_seen), .ovf(seen_full_err)
    );

    // Choose the class, with a real hit taking priority.
    always_comb begin
        if (real_hit)        cls = CLS_HIT;
        else if (!was_seen)  cls = CLS_COLD;
        else if (shadow_hit) cls = CLS_CONFLICT;
        else                 cls = CLS_CAPACITY;
    end

    // Register the result one cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_class <= 2'b00;
        end else begin
            res_valid <= acc_valid;
            if (acc_valid) res_class <= cls;
        end
    end
endmodule

// File: rtl/cmc_checker.sv
// Temporal checks on the classifier ports, bound to every instance.
module cmc_checker #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic [ADDR_W-1:0] acc_addr,
    input logic              res_valid,
    input logic [1:0]        res_class,
    input logic              seen_full_err
);
    // R3
    res_follows_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> res_valid);
    // R3
    no_spurious_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !res_valid);
    // R2
    class_known_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> !$isunknown(res_class));
    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seen_full_err |=> seen_full_err);
    // R11
    repeat_line_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && $past(acc_valid) && $past(rst_n) &&
         acc_addr[ADDR_W-1:OFF_W] == $past(acc_addr[ADDR_W-1:OFF_W]))
        |=> (res_class == 2'b00));
endmodule

bind cache_miss_classifier cmc_checker #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .res_valid(res_valid), .res_class(res_class), .seen_full_err(seen_full_err)
);

// File: tb/cache_miss_classifier_tb.sv
// Directed bench: a direct-mapped instance and a 2-way instance share stimulus.
module cache_miss_classifier_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic        dm_vld, w2_vld, dm_err, w2_err;
    logic [1:0]  dm_cls, w2_cls;
    int          checks = 0;
    int          errors = 0;

    always #10 clk = ~clk;

    cache_miss_classifier #(.WAYS(1), .SEEN_DEPTH(16)) u_dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .res_valid(dm_vld), .res_class(dm_cls), .seen_full_err(dm_err)
    );
    cache_miss_classifier #(.WAYS(2), .SEEN_DEPTH(16)) u_dut_2way (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .res_valid(w2_vld), .res_class(w2_cls), .seen_full_err(w2_err)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0; acc_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One access; returns at the falling edge where its result is visible.
    task automatic do_acc(input logic [31:0] a);
        @(negedge clk); acc_valid = 1'b1; acc_addr = a;
        @(negedge clk); acc_valid = 1'b0;
    endtask

    task automatic t_reset_state();
        do_reset();
        chk("R10 res_valid after reset", dm_vld, 0);
        chk("R10 err after reset", dm_err, 0);
    endtask

    task automatic t_cold_hit_offset();
        do_reset();
        do_acc(32'h0000_0000); chk("R4 first touch cold", dm_cls, 2'b01);
        chk("R3 res_valid one cycle later", dm_vld, 1);
        @(negedge clk);        chk("R3 res_valid drops", dm_vld, 0);
        do_acc(32'h0000_000F); chk("R1 offset ignored hit", dm_cls, 2'b00);
        do_acc(32'h0000_0004); chk("R2 hit code", dm_cls, 2'b00);
    endtask

    task automatic t_conflict();
        do_reset();
        do_acc(32'h0000_0000);
        do_acc(32'h0000_0080); chk("R4 second line cold", dm_cls, 2'b01);
        do_acc(32'h0000_0000);
        chk("R5 direct mapped conflict", dm_cls, 2'b10);
        chk("R1 2-way holds both lines", w2_cls, 2'b00);
    endtask

    task automatic t_capacity();
        do_reset();
        for (int i = 0; i < 8; i++) do_acc(32'(i * 16));
        do_acc(32'h0000_0080);
        do_acc(32'h0000_0000); chk("R6 capacity miss", dm_cls, 2'b11);
    endtask

    task automatic t_shadow_lru();
        do_reset();
        for (int i = 0; i < 8; i++) do_acc(32'(i * 16));
        do_acc(32'h0000_0000); chk("R8 refresh hit", dm_cls, 2'b00);
        do_acc(32'h0000_0080); chk("R8 new line cold", dm_cls, 2'b01);
        do_acc(32'h0000_0000); chk("R8 shadow kept recent line", dm_cls, 2'b10);
        do_acc(32'h0000_0010); chk("R1 index 1 still resident", dm_cls, 2'b00);
    endtask

    task automatic t_real_lru();
        do_reset();
        do_acc(32'h0000_0000);
        do_acc(32'h0000_0040);
        do_acc(32'h0000_0000); chk("R7 2-way hit", w2_cls, 2'b00);
        do_acc(32'h0000_0080); chk("R7 third line cold", w2_cls, 2'b01);
        do_acc(32'h0000_0000); chk("R7 recent way kept", w2_cls, 2'b00);
        do_acc(32'h0000_0040); chk("R7 LRU way evicted", w2_cls, 2'b10);
    endtask

    task automatic t_back_to_back();
        do_reset();
        @(negedge clk); acc_valid = 1'b1; acc_addr = 32'h0000_0100;
        @(negedge clk); acc_addr = 32'h0000_0104;
        chk("R11 first of burst cold", dm_cls, 2'b01);
        @(negedge clk); acc_valid = 1'b0;
        chk("R11 second of burst hit", dm_cls, 2'b00);
        chk("R11 second result valid", dm_vld, 1);
    endtask

    task automatic t_overflow();
        do_reset();
        for (int i = 0; i < 16; i++) do_acc(32'(i * 16));
        chk("R9 record full no error", dm_err, 0);
        do_acc(32'h0000_0100); chk("R9 overflow flag", dm_err, 1);
        do_acc(32'h0000_0000); chk("R9 flag sticky", dm_err, 1);
        do_reset();
        chk("R10 reset clears flag", dm_err, 0);
        do_acc(32'h0000_0000); chk("R10 record cleared cold", dm_cls, 2'b01);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset_state();
        t_cold_hit_offset();
        t_conflict();
        t_capacity();
        t_shadow_lru();
        t_real_lru();
        t_back_to_back();
        t_overflow();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule